// File: doc/BRIEF.md
# SPI Flash Write-Permission Front End

This block sits on the slave side of a serial flash's SPI port and owns the state that decides whether the array may be written. It oversamples chip-select, serial clock and serial input in the system clock domain, shifts each command in most significant bit first, and acts on the command only when chip-select returns high. The state it keeps is a write-enable flag, an auto-increment program flag, a status-write arming flag and the non-decoded protection bits of the status byte.

Program and erase opcodes go through a gate. An accepted command gives a one-cycle start strobe to the program engine. A refused one gives a reject strobe instead. A status-byte write takes effect only when the arming command came directly before it or when writes are enabled. Any other complete command in between cancels the arming. The serial output stays in high impedance for all of these commands. The busy indication is an input from the program engine and is mirrored into the status byte.

Top module: `spi_wr_guard`

## Requirements
- R1: After a synchronous reset, `status_o` is 0x00 while `prog_busy` is low, and `wel_o`, `aai_o`, `wr_allow_o` and every strobe output are 0.
- R2: A frame carrying opcode 0x06 sets the write-enable flag, which is visible as `wel_o` and as status bit 1.
- R3: Opcode 0x04 clears both the write-enable flag and the auto-increment flag (status bit 6). Status bit 0 continues to follow `prog_busy`, so an operation in progress stays busy.
- R4: The program and erase opcodes are 0x02, 0xAD, 0x20, 0x52, 0xD8, 0x60 and 0xC7. Such a command pulses `pgm_start_o` only if write-enable is 1 and busy is 0; otherwise it pulses `pgm_reject_o`. An accepted command other than 0xAD clears write-enable. `wr_allow_o` equals write-enable AND NOT busy.
- R5: Opcode 0x01 followed by one data byte writes status bits 7 and 5..2 from that byte and pulses `sr_wr_o`, provided the arming flag or write-enable is set. On acceptance it clears both flags.
- R6: Opcode 0x50 arms a status write. Any other complete command that is not 0x01 disarms it. An opcode 0x01 frame that has no data byte is one such command.
- R7: A frame whose bit count at chip-select rise is not a multiple of 8 has no effect on any state, including the arming flag.
- R8: Shifting in all 8 bits of a command does not change any state while chip-select is still low. The effect appears after chip-select rises.
- R9: SPI mode 0 (clock idle low) and mode 3 (clock idle high) both work. Input is sampled on the rising clock edge.
- R10: `so_en` stays 0 at all times.
- R11: An accepted 0xAD command sets the auto-increment flag (status bit 6) and leaves write-enable set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, asynchronous |
| spi_cs_n | input | 1 | SPI chip-select, active low |
| spi_si | input | 1 | SPI serial data in |
| prog_busy | input | 1 | Busy from the program engine |
| so_dat | output | 1 | Serial output data (held 0) |
| so_en | output | 1 | Serial output enable, 0 = high impedance |
| wel_o | output | 1 | Write-enable flag |
| aai_o | output | 1 | Auto-increment program flag |
| wr_allow_o | output | 1 | Write-enable and not busy |
| status_o | output | 8 | Status byte: bit0 busy, bit1 write-enable, bit6 auto-increment |
| pgm_start_o | output | 1 | One-cycle start strobe for an accepted program or erase |
| pgm_op_o | output | 8 | Opcode of the accepted command |
| pgm_reject_o | output | 1 | One-cycle strobe for a refused program or erase |
| sr_wr_o | output | 1 | One-cycle strobe for an accepted status write |
| sr_data_o | output | 8 | Data byte of the accepted status write |

## Verification
A wrong write-enable or auto-increment value shows at `status_o` and `wel_o` within a few clocks of the chip-select rise that should have changed it. It also decides whether the next program opcode gives a start or a reject strobe. A stale arming flag has no output of its own, so it shows up only through the next status write, which is either wrongly accepted or wrongly refused. The sequences therefore place commands between the arming and the write, and place malformed frames there too. A premature update is caught by sampling the outputs while chip-select is still low after a full opcode.

// File: rtl/spi_wr_pkg.sv
package spi_wr_pkg;

  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] OPC_SET_WE = 8'h06;
  localparam logic [BYTE_W-1:0] OPC_CLR_WE = 8'h04;
  localparam logic [BYTE_W-1:0] OPC_ARM_SR = 8'h50;
  localparam logic [BYTE_W-1:0] OPC_WR_SR  = 8'h01;
  localparam logic [BYTE_W-1:0] OPC_AAI    = 8'hAD;

  localparam int ST_BUSY = 0;
  localparam int ST_WE   = 1;
  localparam int ST_AAI  = 6;

  // status bits that a status write may change
  localparam logic [BYTE_W-1:0] SR_KEEP_MASK = 8'hBC;

  typedef struct packed {
    logic              valid;
    logic              has_data;
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] dat;
  } frame_t;

  function automatic logic is_prog_op(input logic [BYTE_W-1:0] op);
    case (op)
      8'h02, 8'hAD, 8'h20, 8'h52, 8'hD8, 8'h60, 8'hC7: return 1'b1;
      default:                                         return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int               WIDTH   = 3,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
  import spi_wr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   sck_s,
  input  logic   csn_s,
  input  logic   si_s,
  output frame_t frame_o
);

  localparam int IDX_W = $clog2(BYTE_W);
  localparam int CNT_W = 2;
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic              sck_q, csn_q;
  logic [IDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  byte_cnt;
  logic [BYTE_W-1:0] sh, opc, dat;
  logic [BYTE_W-1:0] sh_nxt;
  logic              sck_rise, cs_rise;

  assign sh_nxt   = {sh[BYTE_W-2:0], si_s};
  assign sck_rise = sck_s & ~sck_q & ~csn_s;
  assign cs_rise  = csn_s & ~csn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      csn_q    <= 1'b1;
      bit_idx  <= '0;
      byte_cnt <= '0;
      sh       <= '0;
      opc      <= '0;
      dat      <= '0;
      frame_o  <= '0;
    end else begin
      sck_q             <= sck_s;
      csn_q             <= csn_s;
      frame_o.valid     <= cs_rise && (bit_idx == '0) && (byte_cnt != '0);
      frame_o.has_data  <= byte_cnt >= CNT_W'(2);
      frame_o.op        <= opc;
      frame_o.dat       <= dat;
      if (csn_s) begin
        bit_idx  <= '0;
        byte_cnt <= '0;
      end else if (sck_rise) begin
        sh      <= sh_nxt;
        bit_idx <= bit_idx + 1'b1;
        if (bit_idx == IDX_LAST) begin
          if (byte_cnt == CNT_W'(0)) opc <= sh_nxt;
          if (byte_cnt == CNT_W'(1)) dat <= sh_nxt;
          if (byte_cnt != CNT_MAX)   byte_cnt <= byte_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_wr_state.sv
module spi_wr_state
  import spi_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  frame_t            frame_i,
  input  logic              prog_busy,
  output logic              wel_o,
  output logic              aai_o,
  output logic              wr_allow_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              pgm_start_o,
  output logic [BYTE_W-1:0] pgm_op_o,
  output logic              pgm_reject_o,
  output logic              sr_wr_o,
  output logic [BYTE_W-1:0] sr_data_o
);

  logic              wel, aai, armed, busy_q;
  logic [BYTE_W-1:0] sr_keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      wel          <= 1'b0;
      aai          <= 1'b0;
      armed        <= 1'b0;
      busy_q       <= 1'b0;
      sr_keep      <= '0;
      pgm_start_o  <= 1'b0;
      pgm_op_o     <= '0;
      pgm_reject_o <= 1'b0;
      sr_wr_o      <= 1'b0;
      sr_data_o    <= '0;
    end else begin
      busy_q       <= prog_busy;
      pgm_start_o  <= 1'b0;
      pgm_reject_o <= 1'b0;
      sr_wr_o      <= 1'b0;
      if (frame_i.valid) begin
        if (frame_i.op == OPC_SET_WE) begin
          wel   <= 1'b1;
          armed <= 1'b0;
        end else if (frame_i.op == OPC_CLR_WE) begin
          wel   <= 1'b0;
          aai   <= 1'b0;
          armed <= 1'b0;
        end else if (frame_i.op == OPC_ARM_SR) begin
          armed <= 1'b1;
        end else if (frame_i.op == OPC_WR_SR) begin
          armed <= 1'b0;
          if (frame_i.has_data && (armed || wel)) begin
            sr_keep   <= frame_i.dat & SR_KEEP_MASK;
            sr_data_o <= frame_i.dat;
            sr_wr_o   <= 1'b1;
            wel       <= 1'b0;
          end
        end else if (is_prog_op(frame_i.op)) begin
          armed <= 1'b0;
          if (wel && !busy_q) begin
            pgm_start_o <= 1'b1;
            pgm_op_o    <= frame_i.op;
            if (frame_i.op == OPC_AAI) aai <= 1'b1;
            else                       wel <= 1'b0;
          end else begin
            pgm_reject_o <= 1'b1;
          end
        end else begin
          armed <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    status_o          = sr_keep;
    status_o[ST_BUSY] = busy_q;
    status_o[ST_WE]   = wel;
    status_o[ST_AAI]  = aai;
  end

  assign wel_o      = wel;
  assign aai_o      = aai;
  assign wr_allow_o = wel & ~busy_q;

endmodule

// File: rtl/spi_wr_guard.sv
module spi_wr_guard
  import spi_wr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              prog_busy,
  output logic              so_dat,
  output logic              so_en,
  output logic              wel_o,
  output logic              aai_o,
  output logic              wr_allow_o,
  output logic [BYTE_W-1:0] status_o,
  output logic              pgm_start_o,
  output logic [BYTE_W-1:0] pgm_op_o,
  output logic              pgm_reject_o,
  output logic              sr_wr_o,
  output logic [BYTE_W-1:0] sr_data_o
);

  localparam int IN_W = 3;

  logic [IN_W-1:0] pins_s;
  frame_t          frame_q;
  logic            frame_valid;
  logic            so_en_q;

  spi_in_sync #(
    .WIDTH  (IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b010)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  ({spi_sck, spi_cs_n, spi_si}),
    .q  (pins_s)
  );

  spi_cmd_shift u_shift (
    .clk    (clk),
    .rst    (rst),
    .sck_s  (pins_s[2]),
    .csn_s  (pins_s[1]),
    .si_s   (pins_s[0]),
    .frame_o(frame_q)
  );

  spi_wr_state u_state (
    .clk         (clk),
    .rst         (rst),
    .frame_i     (frame_q),
    .prog_busy   (prog_busy),
    .wel_o       (wel_o),
    .aai_o       (aai_o),
    .wr_allow_o  (wr_allow_o),
    .status_o    (status_o),
    .pgm_start_o (pgm_start_o),
    .pgm_op_o    (pgm_op_o),
    .pgm_reject_o(pgm_reject_o),
    .sr_wr_o     (sr_wr_o),
    .sr_data_o   (sr_data_o)
  );

  assign frame_valid = frame_q.valid;

  // no command handled here returns data
  always_ff @(posedge clk) begin
    if (rst) so_en_q <= 1'b0;
    else     so_en_q <= 1'b0;
  end

  assign so_en  = so_en_q;
  assign so_dat = 1'b0;

endmodule

// File: rtl/spi_wr_guard_chk.sv
module spi_wr_guard_chk (
  input logic clk,
  input logic rst,
  input logic so_en,
  input logic wel_o,
  input logic aai_o,
  input logic pgm_start_o,
  input logic pgm_reject_o,
  input logic sr_wr_o,
  input logic frame_valid
);

  AST_SO_HIZ: assert property (@(posedge clk) disable iff (rst) !so_en); // R10
  AST_WEL_AT_FRAME: assert property (@(posedge clk) disable iff (rst) !$stable(wel_o) |-> $past(frame_valid)); // R8
  AST_AAI_AT_FRAME: assert property (@(posedge clk) disable iff (rst) !$stable(aai_o) |-> $past(frame_valid)); // R8
  AST_START_NEEDS_WEL: assert property (@(posedge clk) disable iff (rst) pgm_start_o |-> $past(wel_o)); // R4
  AST_START_OR_REJECT: assert property (@(posedge clk) disable iff (rst) !(pgm_start_o && pgm_reject_o)); // R4
  AST_SRW_DROPS_WEL: assert property (@(posedge clk) disable iff (rst) sr_wr_o |-> !wel_o); // R5

endmodule

bind spi_wr_guard spi_wr_guard_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .so_en       (so_en),
  .wel_o       (wel_o),
  .aai_o       (aai_o),
  .pgm_start_o (pgm_start_o),
  .pgm_reject_o(pgm_reject_o),
  .sr_wr_o     (sr_wr_o),
  .frame_valid (frame_valid)
);

// File: tb/spi_wr_guard_tb.sv
module spi_wr_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int SETTLE     = 12;
  localparam int NVEC       = 20;

  // mode3, nbits, pattern (MSB first), busy, status, start, reject, srw
  typedef struct packed {
    logic        m3;
    logic [5:0]  nbits;
    logic [31:0] pat;
    logic        busy;
    logic [7:0]  st;
    logic        st_p;
    logic        rj_p;
    logic        sw_p;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    {1'b0, 6'd8,  32'h0600_0000, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'd8,  32'h0400_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 6'd16, 32'h02AB_0000, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0},
    {1'b1, 6'd8,  32'h0600_0000, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
    {1'b0, 6'd32, 32'h2012_3456, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0},
    {1'b1, 6'd8,  32'h0600_0000, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
    {1'b0, 6'd16, 32'hAD55_0000, 1'b0, 8'h42, 1'b1, 1'b0, 1'b0},
    {1'b1, 6'd8,  32'h0400_0000, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0},
    {1'b0, 6'd8,  32'h0600_0000, 1'b1, 8'h03, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'd8,  32'hD800_0000, 1'b1, 8'h03, 1'b0, 1'b1, 1'b0},
    {1'b0, 6'd7,  32'h0400_0000, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'd8,  32'h0400_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 6'd8,  32'h5000_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'd8,  32'h0600_0000, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0},
    {1'b0, 6'd8,  32'h0400_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'd16, 32'h01FF_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 6'd8,  32'h5000_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'd16, 32'h01BC_0000, 1'b0, 8'hBC, 1'b0, 1'b0, 1'b1},
    {1'b0, 6'd8,  32'h0600_0000, 1'b0, 8'hBE, 1'b0, 1'b0, 1'b0},
    {1'b1, 6'd16, 32'h0100_0000, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 5, 8, 18:   return "R2";
      1, 7, 11:      return "R3";
      2, 4, 9:       return "R4";
      3:             return "R9";
      6:             return "R11";
      10:            return "R7";
      13, 14, 15:    return "R6";
      default:       return "R5";
    endcase
  endfunction

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_si = 1'b0;
  logic       prog_busy = 1'b0;
  logic       so_dat, so_en, wel_o, aai_o, wr_allow_o;
  logic [7:0] status_o, pgm_op_o, sr_data_o;
  logic       pgm_start_o, pgm_reject_o, sr_wr_o;

  int n_tests = 0;
  int n_fail  = 0;
  int n_start = 0;
  int n_rej   = 0;
  int n_srw   = 0;
  int n_soen  = 0;
  bit done    = 1'b0;

  spi_wr_guard u_dut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_si(spi_si), .prog_busy(prog_busy), .so_dat(so_dat), .so_en(so_en),
    .wel_o(wel_o), .aai_o(aai_o), .wr_allow_o(wr_allow_o), .status_o(status_o),
    .pgm_start_o(pgm_start_o), .pgm_op_o(pgm_op_o), .pgm_reject_o(pgm_reject_o),
    .sr_wr_o(sr_wr_o), .sr_data_o(sr_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst) begin
      if (pgm_start_o)  n_start++;
      if (pgm_reject_o) n_rej++;
      if (sr_wr_o)      n_srw++;
      if (so_en)        n_soen++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fr_open(input bit m3);
    spi_sck = m3;
    wait_clk(3);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic fr_bits(input bit m3, input int n, input logic [31:0] pat);
    for (int i = 0; i < n; i++) begin
      if (m3) spi_sck = 1'b0;
      spi_si = pat[31-i];
      wait_clk(HALF);
      spi_sck = 1'b1;
      wait_clk(HALF);
      if (!m3) spi_sck = 1'b0;
    end
  endtask

  task automatic fr_close();
    wait_clk(HALF);
    spi_cs_n = 1'b1;
    wait_clk(SETTLE);
  endtask

  task automatic frame(input bit m3, input int n, input logic [31:0] pat);
    fr_open(m3);
    fr_bits(m3, n, pat);
    fr_close();
  endtask

  initial begin
    wait_clk(100000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int s0, r0, w0;
    wait_clk(5);
    rst = 1'b0;
    wait_clk(3);
    // R1: reset state
    chk(status_o == 8'h00, "R1", "status after reset", status_o, 8'h00);
    chk({wel_o, aai_o, wr_allow_o, pgm_start_o, pgm_reject_o, sr_wr_o} == 6'b0,
        "R1", "flags after reset",
        {wel_o, aai_o, wr_allow_o, pgm_start_o, pgm_reject_o, sr_wr_o}, 6'b0);

    for (int i = 0; i < NVEC; i++) begin
      prog_busy = VEC[i].busy;
      s0 = n_start; r0 = n_rej; w0 = n_srw;
      frame(VEC[i].m3, int'(VEC[i].nbits), VEC[i].pat);
      chk(status_o == VEC[i].st, row_tag(i), $sformatf("row %0d status", i),
          status_o, VEC[i].st);
      chk((n_start - s0 == int'(VEC[i].st_p)) && (n_rej - r0 == int'(VEC[i].rj_p)) &&
          (n_srw - w0 == int'(VEC[i].sw_p)), row_tag(i), $sformatf("row %0d strobes", i),
          {n_start - s0, n_rej - r0, n_srw - w0}[31:0],
          {VEC[i].st_p, VEC[i].rj_p, VEC[i].sw_p});
      // R4: write-allowed output follows write-enable and busy
      chk(wr_allow_o == (VEC[i].st[1] & ~VEC[i].st[0]), "R4",
          $sformatf("row %0d wr_allow", i), wr_allow_o, VEC[i].st[1] & ~VEC[i].st[0]);
      if (i == 4 || i == 6)
        chk(pgm_op_o == VEC[i].pat[31:24], "R4", "start opcode", pgm_op_o, VEC[i].pat[31:24]);
      if (i == 17)
        chk(sr_data_o == 8'hBC, "R5", "status write data", sr_data_o, 8'hBC);
    end

    // R8: full opcode shifted, chip-select still low
    fr_open(1'b0);
    fr_bits(1'b0, 8, 32'h0600_0000);
    wait_clk(20);
    chk(wel_o == 1'b0, "R8", "wel before cs rise", wel_o, 1'b0);
    chk(so_en == 1'b0, "R10", "so_en during frame", so_en, 1'b0);
    fr_close();
    chk(wel_o == 1'b1, "R8", "wel after cs rise", wel_o, 1'b1);
    frame(1'b1, 8, 32'h0400_0000);

    // R7: malformed frame between arm and write keeps arming
    frame(1'b0, 8, 32'h5000_0000);
    frame(1'b1, 9, 32'h0680_0000);
    chk(status_o == 8'h00, "R7", "9-bit frame ignored", status_o, 8'h00);
    w0 = n_srw;
    frame(1'b0, 16, 32'h0184_0000);
    chk(n_srw - w0 == 1, "R7", "arming kept across bad frame", n_srw - w0, 1);
    chk(status_o == 8'h84, "R5", "status after write", status_o, 8'h84);

    // R6: write without data byte disarms
    frame(1'b1, 8, 32'h5000_0000);
    frame(1'b0, 8, 32'h0100_0000);
    w0 = n_srw;
    frame(1'b1, 16, 32'h0100_0000);
    chk(n_srw - w0 == 0, "R6", "short write disarms", n_srw - w0, 0);
    chk(status_o == 8'h84, "R6", "status kept", status_o, 8'h84);

    // R1: reset in the middle of a run
    frame(1'b0, 8, 32'h0600_0000);
    @(negedge clk) rst = 1'b1;
    wait_clk(2);
    rst = 1'b0;
    wait_clk(2);
    chk(status_o == 8'h00 && wel_o == 1'b0, "R1", "status after mid reset",
        status_o, 8'h00);

    chk(n_soen == 0, "R10", "so_en high cycles", n_soen, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule